// File: doc/BRIEF.md
# GPIO bank interrupt controller

This block turns the levels of 32 already-synchronised GPIO inputs into interrupt requests. Each pin is set up through registers. It can fire on a rising edge, a falling edge, both edges, a high level or a low level. Edge events are held in a per-pin latch until software acknowledges them. Level conditions track the pin directly.

Software sees two status views. The raw view shows every pending condition. The masked view shows only the conditions that are allowed through. The OR of the masked view drives a single registered interrupt line to the system interrupt controller. A constant identifier register lets software find out which block it is talking to.

After reset, every pin is masked and enabled. Software only has to choose a trigger and clear a mask bit to start taking interrupts.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the enable and mask registers read all ones. Type, polarity and both-edge read zero. `irq_o` is low.
- R2: Type bit 1 means edge. With polarity 1, a rising edge latches the pin's raw status bit. With polarity 0, a falling edge latches it. The transition is compared against the previous cycle's pin value, and the bit is set at the clock edge that samples the new value.
- R3: With type 1 and the pin's both-edge bit at 1, both rising and falling transitions latch the pin, and the polarity bit is ignored.
- R4: Type bit 0 means level. Polarity 1 means active high and polarity 0 means active low. The raw bit follows the pin while the condition holds, is never latched, and is not affected by end-of-interrupt writes.
- R5: A pin whose enable bit is 0 shows no level condition and latches no new edge.
- R6: A mask bit of 1 removes the pin from the masked status register and from `irq_o`. The raw status register is not affected by masking.
- R7: Writing 1 to a pin's bit in the end-of-interrupt register clears that pin's latched edge. Writing 0 leaves it latched.
- R8: An edge detected in the same cycle as its own end-of-interrupt write stays latched.
- R9: `irq_o` is the OR of all masked status bits, registered: it reflects the status of the previous cycle.
- R10: The identifier register at word offset 8 reads 0x01000C2B.
- R11: The register word offsets are as follows:
  - enable 0
  - mask 1
  - type 2
  - polarity 3
  - both-edge 4
  - end-of-interrupt 5 (reads 0)
  - raw status 6
  - masked status 7
  - identifier 8

  Any other offset reads 0. Read data appears on `rdata_o` in the cycle after the request and reflects the state before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | 32 | Synchronised pin levels |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a new edge that arrives in the very cycle its acknowledge is written. This can only happen when a pin transition and an end-of-interrupt write meet on the same clock edge. The bench sets up that collision on purpose: it drives the pin change in the same cycle as the acknowledge write and then reads the raw status back. A long stretch of random pin activity, mixed with random configuration writes and acknowledges, then drives all pins together against the behavioural model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam logic [DATA_W-1:0] VERSION_ID = 32'h0100_0C2B;

  typedef enum logic [ADDR_W-1:0] {
    REG_EN   = 4'd0,
    REG_MASK = 4'd1,
    REG_TYPE = 4'd2,
    REG_POL  = 4'd3,
    REG_BOTH = 4'd4,
    REG_EOI  = 4'd5,
    REG_RAW  = 4'd6,
    REG_STAT = 4'd7,
    REG_VER  = 4'd8
  } reg_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NUM_PINS-1:0] en_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] type_o,
  output logic [NUM_PINS-1:0] pol_o,
  output logic [NUM_PINS-1:0] both_o,
  output logic [NUM_PINS-1:0] eoi_o
);
  logic                wr;
  logic [NUM_PINS-1:0] wval;

  assign wr   = req_i && we_i;
  assign wval = wdata_i[NUM_PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '1;
      mask_o <= '1;
      type_o <= '0;
      pol_o  <= '0;
      both_o <= '0;
    end else if (wr) begin
      case (addr_i)
        REG_EN:   en_o   <= wval;
        REG_MASK: mask_o <= wval;
        REG_TYPE: type_o <= wval;
        REG_POL:  pol_o  <= wval;
        REG_BOTH: both_o <= wval;
        default: ;
      endcase
    end
  end

  // acknowledge is a single-cycle pulse, write-one-to-clear
  assign eoi_o = (wr && addr_i == REG_EOI) ? wval : '0;

  assert_reset_mask_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (&mask_o) && (&en_o));
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic en_i,
  input  logic type_i,
  input  logic pol_i,
  input  logic both_i,
  input  logic clr_i,
  output logic raw_o
);
  logic pin_q, pend_q;
  logic rise, fall, edge_hit, level_hit;

  assign rise = pin_i & ~pin_q;
  assign fall = ~pin_i & pin_q;

  always_comb begin
    if (both_i) edge_hit = rise | fall;
    else        edge_hit = pol_i ? rise : fall;
    edge_hit  = edge_hit & en_i & type_i;
    level_hit = en_i & ~type_i & (pol_i ? pin_i : ~pin_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pin_q  <= pin_i;
      // new edge wins over a simultaneous acknowledge
      pend_q <= (pend_q & ~clr_i) | edge_hit;
    end
  end

  assign raw_o = pend_q | level_hit;

  assert_ack_race_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_hit && clr_i |=> pend_q);
  assert_eoi_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clr_i |=> pend_q);
  assert_eoi_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && clr_i && !edge_hit |=> !pend_q);
  assert_disabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q && !en_i |=> !pend_q);
endmodule

// File: rtl/gpio_irq_rdmux.sv
module gpio_irq_rdmux
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] en_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] type_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] both_i,
  input  logic [NUM_PINS-1:0] raw_i,
  input  logic [NUM_PINS-1:0] stat_i,
  output logic [DATA_W-1:0]   rdata_o
);
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    case (addr_i)
      REG_EN:   rd_d = DATA_W'(en_i);
      REG_MASK: rd_d = DATA_W'(mask_i);
      REG_TYPE: rd_d = DATA_W'(type_i);
      REG_POL:  rd_d = DATA_W'(pol_i);
      REG_BOTH: rd_d = DATA_W'(both_i);
      REG_RAW:  rd_d = DATA_W'(raw_i);
      REG_STAT: rd_d = DATA_W'(stat_i);
      REG_VER:  rd_d = VERSION_ID;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_o <= '0;
    else if (req_i && !we_i)    rdata_o <= rd_d;
  end

  assert_version_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && addr_i == REG_VER |=> rdata_o == VERSION_ID);
  assert_eoi_reads_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && addr_i == REG_EOI |=> rdata_o == '0);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] en, mask, typ, pol, both, eoi, raw, stat;

  gpio_irq_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .en_o(en), .mask_o(mask), .type_o(typ), .pol_o(pol),
    .both_o(both), .eoi_o(eoi)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_irq_pin u_pin (
      .clk_i, .rst_ni,
      .pin_i (pins_i[i]),
      .en_i  (en[i]),
      .type_i(typ[i]),
      .pol_i (pol[i]),
      .both_i(both[i]),
      .clr_i (eoi[i]),
      .raw_o (raw[i])
    );
  end

  assign stat = raw & ~mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |stat;
  end

  gpio_irq_rdmux #(.NUM_PINS(NUM_PINS)) u_rd (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .en_i(en), .mask_i(mask), .type_i(typ), .pol_i(pol), .both_i(both),
    .raw_i(raw), .stat_i(stat), .rdata_o
  );

  assert_mask_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask) |=> !irq_o);
  assert_irq_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(raw & ~mask)) |=> irq_o);
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [31:0] pins_i = '0;
  logic        req_i = 0, we_i = 0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  gpio_irq_ctrl dut (.*);

  always #5 clk_i = ~clk_i;

  int vectors = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural model state
  logic [31:0] m_en = '1, m_mask = '1, m_type = '0, m_pol = '0, m_both = '0;
  logic [31:0] m_pinq = '0, m_pend = '0, m_rdata = '0;
  logic        m_irq = 0;

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  function automatic logic [31:0] raw_now();
    logic [31:0] lvl;
    lvl = m_en & ~m_type & ((m_pol & pins_i) | (~m_pol & ~pins_i));
    return m_pend | lvl;
  endfunction

  task automatic tick(bit rq, bit w, logic [3:0] a, logic [31:0] d);
    logic [31:0] raw, stat, rise, fall, hit, clr, exp_rd;
    bit is_rd;
    req_i = rq; we_i = w; addr_i = a; wdata_i = d;
    raw  = raw_now();
    stat = raw & ~m_mask;
    rise = pins_i & ~m_pinq;
    fall = ~pins_i & m_pinq;
    hit  = m_en & m_type & ((m_both & (rise | fall)) |
           (~m_both & ((m_pol & rise) | (~m_pol & fall))));
    clr  = (rq && w && a == 4'd5) ? d : '0;
    is_rd = rq && !w;
    case (a)
      4'd0: exp_rd = m_en;
      4'd1: exp_rd = m_mask;
      4'd2: exp_rd = m_type;
      4'd3: exp_rd = m_pol;
      4'd4: exp_rd = m_both;
      4'd6: exp_rd = raw;
      4'd7: exp_rd = stat;
      4'd8: exp_rd = 32'h0100_0C2B;
      default: exp_rd = '0;
    endcase
    @(posedge clk_i); #1;
    m_pend = (m_pend & ~clr) | hit;
    m_pinq = pins_i;
    m_irq  = |stat;
    if (is_rd) m_rdata = exp_rd;
    if (rq && w) begin
      case (a)
        4'd0: m_en   = d;
        4'd1: m_mask = d;
        4'd2: m_type = d;
        4'd3: m_pol  = d;
        4'd4: m_both = d;
        default: ;
      endcase
    end
    req_i = 0; we_i = 0;
    @(negedge clk_i);
    check({tag, " irq"}, {31'b0, irq_o}, {31'b0, m_irq});
    if (is_rd) check({tag, " rdata"}, rdata_o, m_rdata);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d); tick(1, 1, a, d); endtask
  task automatic rd(logic [3:0] a);                 tick(1, 0, a, '0); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) tick(0, 0, '0, '0); endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1;
    // R1 reset state, R10 id, R11 map readback
    tag = "R1";
    check("R1 irq after reset", {31'b0, irq_o}, 32'd0);
    for (int a = 0; a < 5; a++) rd(4'(a));
    tag = "R10"; rd(4'd8);
    tag = "R11"; rd(4'd5); rd(4'd6); rd(4'd7); rd(4'd12);

    // R2 edge triggers
    tag = "R2";
    wr(4'd2, '1); wr(4'd3, 32'h0000_FFFF); wr(4'd1, 32'h0); idle(1);
    pins_i[0] = 1; idle(1); rd(4'd6);
    pins_i[20] = 1; idle(1); rd(4'd6);
    pins_i[20] = 0; idle(1); rd(4'd6); rd(4'd7);
    tag = "R9"; idle(2);

    // R7 acknowledge semantics
    tag = "R7";
    wr(4'd5, 32'h0); rd(4'd6);
    wr(4'd5, 32'h0000_0001); rd(4'd6);
    wr(4'd5, 32'h0010_0000); rd(4'd6); idle(1);

    // R3 both edges, polarity ignored
    tag = "R3";
    wr(4'd4, 32'h0000_0020);
    pins_i[5] = 1; idle(1); rd(4'd6); wr(4'd5, 32'h20);
    pins_i[5] = 0; idle(1); rd(4'd6); wr(4'd5, 32'h20); rd(4'd6);

    // R8 edge together with its own acknowledge
    tag = "R8";
    pins_i[0] = 0; idle(1); wr(4'd5, '1); rd(4'd6);
    pins_i[0] = 1; wr(4'd5, 32'h1); rd(4'd6); rd(4'd7);
    wr(4'd5, 32'h1); rd(4'd6);

    // R4 level triggers
    tag = "R4";
    wr(4'd2, 32'hFFFF_F0FF); wr(4'd3, 32'h0000_F1FF);
    pins_i[8] = 1; pins_i[9] = 1; idle(1); rd(4'd6);
    wr(4'd5, 32'h0000_0300); rd(4'd6);
    pins_i[8] = 0; pins_i[9] = 0; idle(1); rd(4'd6); rd(4'd7);
    pins_i[9] = 1; idle(1); rd(4'd6);

    // R5 disabled pins
    tag = "R5";
    wr(4'd0, 32'hFFFF_EDFF);
    pins_i[12] = 1; idle(1); pins_i[12] = 0; idle(1);
    pins_i[9] = 0; idle(1); rd(4'd6); wr(4'd0, '1); rd(4'd6);

    // R6 masking
    tag = "R6";
    pins_i[1] = 1; idle(1);
    wr(4'd1, '1); idle(2); rd(4'd6); rd(4'd7);
    wr(4'd1, 32'h0000_0002); idle(1); rd(4'd7);

    // R9 random mix
    tag = "R9";
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if ((n % 3) == 0) pins_i = $urandom;
      else if (r < 2) pins_i[$urandom_range(0, 31)] ^= 1'b1;
      if (r == 7)      wr(4'($urandom_range(0, 5)), $urandom);
      else if (r >= 8) rd(4'($urandom_range(0, 9)));
      else             idle(1);
    end
    report();
  end
endmodule